// File: doc/BRIEF.md
# Interrupt Acknowledge and Cascade Sequencer

This block runs the CPU side of an interrupt controller once a priority level has already won arbitration. The CPU answers an interrupt with a train of active-low acknowledge pulses. On each pulse the sequencer decides whether this device should answer, and if so which byte it puts on the 8-bit data bus. With an 8-bit processor the train has three pulses: a subroutine-call opcode, then the low byte of the handler address, then its high byte. With a 16-bit processor the train has two pulses. The first pulse drives nothing, and the second returns a vector type byte.

In a cascaded system one device acts as master and up to eight others act as slaves. The master always supplies the call opcode. During the whole train it also drives the serviced level number on three cascade lines. A slave wired to that level compares the lines with its own identity and supplies the remaining bytes. When no slave sits behind the serviced level, the master answers every byte itself. The role comes from an input pin, or from a configuration bit when the device works behind an external data buffer. In that buffered case the sequencer also drives a buffer enable. It reports in-service set and clear events as one-hot pulses, and the clear pulse is how automatic end-of-interrupt is carried out.

Top module: `iack_cascade_seq`

## Requirements
- R1: After reset, data_oe, buf_en, cas_out, isr_set and isr_clr are all zero.
- R2: The data outputs change only on clock edges. An acknowledge falling edge is sampled on one rising clock edge, and the response byte is on data_out with data_oe high from that edge onward. data_oe drops on the clock edge that samples inta_n high again.
- R3: With cfg_cpu16=0 and a device that answers all bytes, the three pulses return 0xCD, then the low address byte, then cfg_vec_addr[15:8].
- R4: With cfg_int4=1, the low address byte is cfg_vec_addr[7:5] with the level times 4 in bits 4:0. With cfg_int4=0, it is cfg_vec_addr[7:6] with the level times 8 in bits 5:0.
- R5: With cfg_cpu16=1, the first pulse drives nothing. The second pulse returns {cfg_type_base, level}, with the level in bits 2:0.
- R6: A cascade master (cfg_cascade=1) holds cas_oe high. From its first pulse until the final pulse ends, it drives cas_out with the level latched at that first pulse. At all other times cas_out is 0.
- R7: A cascade master drives the call opcode on the first pulse. On the later pulses it drives a byte only when bit [level] of cfg_slave_map is 0.
- R8: A cascade slave never drives on the first pulse. It drives the address or type bytes only when cas_in equals cfg_my_id at the start of the second pulse.
- R9: The role is master when role_pin=1 in non-buffered mode, or when cfg_buf_master=1 in buffered mode. buf_en equals data_oe in buffered mode and is 0 otherwise.
- R10: isr_set pulses one-hot for one cycle. A master or single device pulses it at the first pulse. A slave pulses it at the second pulse, and only when selected.
- R11: With cfg_aeoi=1, isr_clr pulses one-hot for the serviced level at the final pulse, on the owning device only. With cfg_aeoi=0 it never pulses.
- R12: After the final pulse ends, the next falling acknowledge edge starts a new sequence at the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inta_n | input | 1 | Active-low acknowledge pulse from the CPU |
| grant_level | input | 3 | Winning level from arbitration, held across the train |
| cfg_cpu16 | input | 1 | 1: two-pulse type-byte protocol; 0: three-pulse call protocol |
| cfg_int4 | input | 1 | 1: vectors 4 bytes apart; 0: 8 bytes apart |
| cfg_vec_addr | input | 16 | Handler base address for the call protocol |
| cfg_type_base | input | 5 | Upper bits of the vector type byte |
| cfg_cascade | input | 1 | 1: device is part of a cascade |
| cfg_buffered | input | 1 | 1: buffered mode, role from cfg_buf_master |
| cfg_buf_master | input | 1 | Role in buffered mode, 1 = master |
| cfg_slave_map | input | 8 | Master: levels that have a slave behind them |
| cfg_my_id | input | 3 | Slave identity |
| cfg_aeoi | input | 1 | Automatic end-of-interrupt enable |
| role_pin | input | 1 | Role in non-buffered mode, 1 = master |
| cas_in | input | 3 | Cascade lines as seen by a slave |
| data_out | output | 8 | Response byte |
| data_oe | output | 1 | Data bus drive enable, bus released when 0 |
| buf_en | output | 1 | External data buffer enable |
| cas_out | output | 3 | Cascade lines driven by a master |
| cas_oe | output | 1 | Cascade line drive enable |
| isr_set | output | 8 | One-hot in-service set pulse |
| isr_clr | output | 8 | One-hot in-service clear pulse (automatic EOI) |

## Verification
The bench sweeps every level under both vector spacings and checks the low address byte against an arithmetic formula. A wrong shift or mask would put the handler at the neighbouring slot. Cascade runs compare levels that have a slave behind them with levels that do not. A design that gets this wrong would have master and slave both drive the same address byte, or have nobody drive it. The slave runs compare a matching cascade code with a mismatching one, because a slave that answers without a match corrupts another slave's vector. The bench also checks that the 16-bit protocol drives nothing on the first pulse. It checks that automatic clearing lands on the final pulse only: clearing one pulse early would let equal-priority requests nest.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_CALL = 3'd1,
    SEL_LO   = 3'd2,
    SEL_HI   = 3'd3,
    SEL_TYPE = 3'd4
  } byte_sel_e;

  localparam logic [7:0] CALL_OPCODE = 8'hCD;
endpackage

// File: rtl/iack_pulse_track.sv
module iack_pulse_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inta_n,
  input  logic       cpu16,
  output logic [1:0] pcount,
  output logic [1:0] last_idx,
  output logic       active,
  output logic       fall_evt,
  output logic       rise_evt,
  output logic       final_fall
);
  logic inta_d;

  assign last_idx   = cpu16 ? 2'd2 : 2'd3;
  assign fall_evt   = inta_d & ~inta_n;
  assign rise_evt   = ~inta_d & inta_n;
  assign active     = ~inta_d;
  assign final_fall = fall_evt && ((pcount == last_idx) ? (last_idx == 2'd1)
                                                         : (pcount + 2'd1 == last_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inta_d <= 1'b1;
      pcount <= 2'd0;
    end else begin
      inta_d <= inta_n;
      if (fall_evt) begin
        if (pcount == last_idx) pcount <= 2'd1;
        else                    pcount <= pcount + 2'd1;
      end else if (rise_evt && pcount == last_idx) begin
        pcount <= 2'd0;
      end
    end
  end

  AST_PCOUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pcount <= last_idx); // R12
  AST_RESTART_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && pcount == last_idx) |=> pcount == 2'd0); // R12
endmodule

// File: rtl/iack_role_ctrl.sv
module iack_role_ctrl
  import iack_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int NUM_LVL = 1 << LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         pcount,
  input  logic [1:0]         last_idx,
  input  logic               active,
  input  logic               fall_evt,
  input  logic               final_fall,
  input  logic               cpu16,
  input  logic               cascade,
  input  logic               buffered,
  input  logic               buf_master,
  input  logic               role_pin,
  input  logic [NUM_LVL-1:0] slave_map,
  input  logic [LVL_W-1:0]   my_id,
  input  logic [LVL_W-1:0]   cas_in,
  input  logic [LVL_W-1:0]   grant_level,
  input  logic               aeoi,
  output byte_sel_e          sel,
  output logic [LVL_W-1:0]   lvl_q,
  output logic [LVL_W-1:0]   cas_out,
  output logic               cas_oe,
  output logic [NUM_LVL-1:0] isr_set,
  output logic [NUM_LVL-1:0] isr_clr
);
  logic is_master, is_slave, slave_behind, cas_match, match_q;
  logic first_fall, second_fall, owner_now, addr_owner;

  function automatic logic [NUM_LVL-1:0] onehot(input logic [LVL_W-1:0] l);
    return NUM_LVL'(1) << l;
  endfunction

  assign is_master    = buffered ? buf_master : role_pin;
  assign is_slave     = cascade & ~is_master;
  assign slave_behind = cascade & is_master & slave_map[lvl_q];
  assign cas_match    = (cas_in == my_id);
  assign first_fall   = fall_evt && (pcount == 2'd0 || pcount == last_idx);
  assign second_fall  = fall_evt && (pcount == 2'd1);
  assign owner_now    = ~is_slave | (second_fall ? cas_match : match_q);
  assign addr_owner   = is_slave ? match_q : ~slave_behind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      match_q <= 1'b0;
      isr_set <= '0;
      isr_clr <= '0;
    end else begin
      if (first_fall) lvl_q <= grant_level;
      if (second_fall)     match_q <= cas_match;
      else if (first_fall) match_q <= 1'b0;
      if (first_fall && !is_slave)                 isr_set <= onehot(grant_level);
      else if (second_fall && is_slave && cas_match) isr_set <= onehot(lvl_q);
      else                                         isr_set <= '0;
      if (final_fall && aeoi && owner_now) isr_clr <= onehot(first_fall ? grant_level : lvl_q);
      else                                 isr_clr <= '0;
    end
  end

  always_comb begin
    sel = SEL_NONE;
    if (active) begin
      case (pcount)
        2'd1: if (!cpu16 && !is_slave) sel = SEL_CALL;
        2'd2: if (addr_owner) sel = cpu16 ? SEL_TYPE : SEL_LO;
        2'd3: if (addr_owner && !cpu16) sel = SEL_HI;
        default: sel = SEL_NONE;
      endcase
    end
  end

  assign cas_oe  = cascade & is_master;
  assign cas_out = (cas_oe && pcount != 2'd0) ? lvl_q : '0;

  AST_SLAVE_NO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (is_slave && pcount == 2'd1) |-> sel == SEL_NONE); // R8
  AST_MASTER_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_behind && pcount >= 2'd2) |-> sel == SEL_NONE); // R7
  AST_CAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_oe && pcount != 2'd0 && $past(pcount) != 2'd0) |-> $stable(cas_out)); // R6
  AST_SET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_set)); // R10
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_clr)); // R11
  AST_CLR_NEEDS_AEOI: assert property (@(posedge clk) disable iff (!rst_n)
    (|isr_clr) |-> $past(aeoi)); // R11
endmodule

// File: rtl/iack_byte_mux.sv
module iack_byte_mux
  import iack_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int DW    = 8
) (
  input  byte_sel_e          sel,
  input  logic [LVL_W-1:0]   lvl,
  input  logic               int4,
  input  logic [2*DW-1:0]    vec_addr,
  input  logic [DW-LVL_W-1:0] type_base,
  output logic [DW-1:0]      data,
  output logic               drive
);
  localparam logic [DW-1:0] MASK4 = DW'((1 << (LVL_W + 2)) - 1);
  localparam logic [DW-1:0] MASK8 = DW'((1 << (LVL_W + 3)) - 1);

  function automatic logic [DW-1:0] low_byte(input logic [DW-1:0] base,
                                              input logic [LVL_W-1:0] l,
                                              input logic four);
    logic [DW-1:0] lx;
    lx = DW'(l);
    if (four) return (base & ~MASK4) | (lx << 2);
    return (base & ~MASK8) | (lx << 3);
  endfunction

  function automatic logic [DW-1:0] type_byte(input logic [DW-LVL_W-1:0] b,
                                               input logic [LVL_W-1:0] l);
    return {b, l};
  endfunction

  always_comb begin
    case (sel)
      SEL_CALL: data = CALL_OPCODE;
      SEL_LO:   data = low_byte(vec_addr[DW-1:0], lvl, int4);
      SEL_HI:   data = vec_addr[2*DW-1:DW];
      SEL_TYPE: data = type_byte(type_base, lvl);
      default:  data = '0;
    endcase
  end

  assign drive = (sel != SEL_NONE);
endmodule

// File: rtl/iack_cascade_seq.sv
module iack_cascade_seq
  import iack_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int DW      = 8,
  parameter int NUM_LVL = 1 << LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inta_n,
  input  logic [LVL_W-1:0]   grant_level,
  input  logic               cfg_cpu16,
  input  logic               cfg_int4,
  input  logic [2*DW-1:0]    cfg_vec_addr,
  input  logic [DW-LVL_W-1:0] cfg_type_base,
  input  logic               cfg_cascade,
  input  logic               cfg_buffered,
  input  logic               cfg_buf_master,
  input  logic [NUM_LVL-1:0] cfg_slave_map,
  input  logic [LVL_W-1:0]   cfg_my_id,
  input  logic               cfg_aeoi,
  input  logic               role_pin,
  input  logic [LVL_W-1:0]   cas_in,
  output logic [DW-1:0]      data_out,
  output logic               data_oe,
  output logic               buf_en,
  output logic [LVL_W-1:0]   cas_out,
  output logic               cas_oe,
  output logic [NUM_LVL-1:0] isr_set,
  output logic [NUM_LVL-1:0] isr_clr
);
  logic [1:0]       pcount, last_idx;
  logic             active, fall_evt, rise_evt, final_fall;
  byte_sel_e        sel;
  logic [LVL_W-1:0] lvl_q;

  iack_pulse_track u_track (
    .clk(clk), .rst_n(rst_n), .inta_n(inta_n), .cpu16(cfg_cpu16),
    .pcount(pcount), .last_idx(last_idx), .active(active),
    .fall_evt(fall_evt), .rise_evt(rise_evt), .final_fall(final_fall)
  );

  iack_role_ctrl #(.LVL_W(LVL_W), .NUM_LVL(NUM_LVL)) u_role (
    .clk(clk), .rst_n(rst_n), .pcount(pcount), .last_idx(last_idx),
    .active(active), .fall_evt(fall_evt), .final_fall(final_fall),
    .cpu16(cfg_cpu16), .cascade(cfg_cascade), .buffered(cfg_buffered),
    .buf_master(cfg_buf_master), .role_pin(role_pin), .slave_map(cfg_slave_map),
    .my_id(cfg_my_id), .cas_in(cas_in), .grant_level(grant_level), .aeoi(cfg_aeoi),
    .sel(sel), .lvl_q(lvl_q), .cas_out(cas_out), .cas_oe(cas_oe),
    .isr_set(isr_set), .isr_clr(isr_clr)
  );

  iack_byte_mux #(.LVL_W(LVL_W), .DW(DW)) u_mux (
    .sel(sel), .lvl(lvl_q), .int4(cfg_int4), .vec_addr(cfg_vec_addr),
    .type_base(cfg_type_base), .data(data_out), .drive(data_oe)
  );

  assign buf_en = cfg_buffered & data_oe;

  AST_BUS_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (active && pcount != 2'd0)); // R2
  AST_RELEASE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !data_oe); // R2
  AST_BUF_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en |-> (data_oe && cfg_buffered)); // R9
endmodule

// File: tb/iack_cascade_seq_tb.sv
module iack_cascade_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inta_n = 1'b1;
  logic [2:0] grant_level = '0;
  logic cfg_cpu16 = 0, cfg_int4 = 0, cfg_cascade = 0, cfg_buffered = 0;
  logic cfg_buf_master = 0, cfg_aeoi = 0, role_pin = 1;
  logic [15:0] cfg_vec_addr = 16'hA5F3;
  logic [4:0]  cfg_type_base = 5'h13;
  logic [7:0]  cfg_slave_map = 8'h00;
  logic [2:0]  cfg_my_id = 3'd5, cas_in = 3'd0;
  logic [7:0] data_out, isr_set, isr_clr;
  logic data_oe, buf_en, cas_oe;
  logic [2:0] cas_out;

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [7:0] g_d[1:3], g_set[1:3], g_clr[1:3];
  logic       g_oe[1:3], g_buf[1:3], g_idle[1:3];
  logic [2:0] g_cas;
  logic [2:0] g_cas_after;

  always #10 clk = ~clk;

  iack_cascade_seq u_dut (
    .clk(clk), .rst_n(rst_n), .inta_n(inta_n), .grant_level(grant_level),
    .cfg_cpu16(cfg_cpu16), .cfg_int4(cfg_int4), .cfg_vec_addr(cfg_vec_addr),
    .cfg_type_base(cfg_type_base), .cfg_cascade(cfg_cascade),
    .cfg_buffered(cfg_buffered), .cfg_buf_master(cfg_buf_master),
    .cfg_slave_map(cfg_slave_map), .cfg_my_id(cfg_my_id), .cfg_aeoi(cfg_aeoi),
    .role_pin(role_pin), .cas_in(cas_in), .data_out(data_out), .data_oe(data_oe),
    .buf_en(buf_en), .cas_out(cas_out), .cas_oe(cas_oe),
    .isr_set(isr_set), .isr_clr(isr_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_seq(input int n);
    for (int p = 1; p <= n; p++) begin
      @(negedge clk) inta_n = 1'b0;
      @(negedge clk);
      g_d[p] = data_out; g_oe[p] = data_oe; g_buf[p] = buf_en;
      g_set[p] = isr_set; g_clr[p] = isr_clr;
      if (p == 1) g_cas = cas_out;
      @(negedge clk) inta_n = 1'b1;
      @(negedge clk);
      g_idle[p] = data_oe;
    end
    g_cas_after = cas_out;
  endtask

  function automatic int lo_exp(input bit four, input int lvl, input int addr);
    if (four) return (addr & 'hE0) + lvl * 4;
    return (addr & 'hC0) + lvl * 8;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(data_oe == 0 && buf_en == 0, "R1 oe", data_oe, 0);
    chk(cas_out == 0 && isr_set == 0 && isr_clr == 0, "R1 regs", isr_set, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(data_oe == 0, "R1 after release", data_oe, 0);

    // R3 R4 R2 R10 R12: single device, 8-bit, both spacings, all levels
    for (int f = 0; f < 2; f++) begin
      for (int l = 0; l < 8; l++) begin
        cfg_int4 = f[0]; grant_level = l[2:0];
        cfg_vec_addr = 16'h3000 + 16'(l * 16'h0111) + (f ? 16'h00B7 : 16'h0049);
        run_seq(3);
        chk(g_oe[1] && g_d[1] == 8'hCD, "R3 call byte", g_d[1], 'hCD);
        chk(g_d[2] == 8'(lo_exp(f[0], l, int'(cfg_vec_addr))), "R4 low byte",
            g_d[2], lo_exp(f[0], l, int'(cfg_vec_addr)));
        chk(g_d[3] == cfg_vec_addr[15:8], "R3 high byte", g_d[3], cfg_vec_addr[15:8]);
        chk(!g_idle[1] && !g_idle[2] && !g_idle[3], "R2 released", g_idle[3], 0);
        chk(g_set[1] == 8'(1 << l) && g_set[2] == 0, "R10 set on first", g_set[1], 1 << l);
        chk(g_clr[3] == 0, "R11 no clear without aeoi", g_clr[3], 0);
        chk(g_buf[1] == 0, "R9 buf_en off unbuffered", g_buf[1], 0);
      end
    end

    // R5 R11: 16-bit protocol with automatic EOI
    cfg_cpu16 = 1; cfg_aeoi = 1;
    for (int l = 0; l < 8; l++) begin
      grant_level = l[2:0];
      run_seq(2);
      chk(!g_oe[1], "R5 first pulse silent", g_oe[1], 0);
      chk(g_oe[2] && g_d[2] == 8'((5'h13 << 3) | l), "R5 type byte", g_d[2], (5'h13 << 3) | l);
      chk(g_clr[1] == 0 && g_clr[2] == 8'(1 << l), "R11 clear on final", g_clr[2], 1 << l);
    end

    // R11 8-bit AEOI on third pulse only
    cfg_cpu16 = 0; grant_level = 3'd6;
    run_seq(3);
    chk(g_clr[2] == 0 && g_clr[3] == 8'h40, "R11 clear third", g_clr[3], 'h40);

    // R6 R7 cascade master
    cfg_aeoi = 0; cfg_cascade = 1; role_pin = 1; cfg_slave_map = 8'b0010_0100;
    for (int l = 0; l < 8; l++) begin
      grant_level = l[2:0];
      run_seq(3);
      chk(cas_oe == 1 && g_cas == 3'(l), "R6 cascade code", g_cas, l);
      chk(g_cas_after == 0, "R6 code dropped", g_cas_after, 0);
      chk(g_oe[1] && g_d[1] == 8'hCD, "R7 master call", g_d[1], 'hCD);
      chk(g_oe[2] == !cfg_slave_map[l] && g_oe[3] == !cfg_slave_map[l],
          "R7 address ownership", g_oe[2], !cfg_slave_map[l]);
    end

    // R8 R10 R11 cascade slave
    role_pin = 0; cfg_aeoi = 1; grant_level = 3'd2; cfg_int4 = 1;
    cfg_vec_addr = 16'h7C40;
    cas_in = 3'd5;
    run_seq(3);
    chk(!g_oe[1], "R8 slave silent first", g_oe[1], 0);
    chk(g_oe[2] && g_d[2] == 8'(lo_exp(1, 2, 'h40)), "R8 slave low byte", g_d[2], lo_exp(1, 2, 'h40));
    chk(g_oe[3] && g_d[3] == 8'h7C, "R8 slave high byte", g_d[3], 'h7C);
    chk(g_set[1] == 0 && g_set[2] == 8'h04, "R10 slave set second", g_set[2], 'h04);
    chk(g_clr[3] == 8'h04, "R11 slave clear", g_clr[3], 'h04);
    chk(cas_oe == 0, "R6 slave no cascade drive", cas_oe, 0);
    cas_in = 3'd3;
    run_seq(3);
    chk(!g_oe[1] && !g_oe[2] && !g_oe[3], "R8 unselected silent", g_oe[2], 0);
    chk(g_set[2] == 0 && g_clr[3] == 0, "R10 unselected no events", g_set[2], 0);
    cfg_cpu16 = 1; cas_in = 3'd5;
    run_seq(2);
    chk(g_oe[2] && g_d[2] == 8'((5'h13 << 3) | 2), "R8 slave type byte", g_d[2], (5'h13 << 3) | 2);

    // R9 buffered role selection
    cfg_cpu16 = 0; cfg_aeoi = 0; cfg_buffered = 1; cfg_buf_master = 1; role_pin = 0;
    cfg_slave_map = 8'h00; grant_level = 3'd1;
    run_seq(3);
    chk(g_oe[1] && g_d[1] == 8'hCD && g_buf[1], "R9 buffered master", g_buf[1], 1);
    chk(cas_oe == 1, "R9 buffered master cascade", cas_oe, 1);
    cfg_buf_master = 0; role_pin = 1; cas_in = 3'd0;
    run_seq(3);
    chk(!g_oe[1] && !g_buf[1] && !g_buf[2], "R9 buffered slave", g_buf[1], 0);

    finish_run();
  end
endmodule